// File: doc/BRIEF.md
# Programmable-Resolution SAR Conversion Sequencer

This block is the digital control side of a successive-approximation converter with an optional sign bit. A host writes one configuration byte over an 8-bit bus. That byte selects an input channel, signed or unsigned conversion, 8-bit or 10-bit magnitude, and left or right justification of the result. The byte is captured when the write strobe returns high while chip select is low, and a conversion starts on that same edge.

A conversion has two phases. First there is a fixed acquisition window. Then there is a run of bit trials, each two clocks long. During the trials the block presents a trial code to an external DAC and reads back a single comparator bit. When the last trial resolves, the interrupt output goes low. The host then reads the result as two bytes, high byte first. A falling read or write strobe with chip select low sets the interrupt high again.

The analog parts sit outside the block: the multiplexer, the DAC, the comparator and the reference. The data pins are split into an input bus, an output bus and an output-enable, and the pad tristate is built from those three signals.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The configuration byte on `bus_din` is captured on the first clock edge where `wr_n` is seen rising while `cs_n` is low. Its fields are:
  - bits [4:0]: channel.
  - bit 5: signed mode.
  - bit 6: 10-bit magnitude (0 selects 8-bit).
  - bit 7: left justification.

  From the next cycle on, `chan_sel` shows bits [4:0], and it changes at no other time.
- R2: After the capture edge, `sample_en` is high for exactly ACQ_CLKS cycles (6 by default), and the bit trials follow at once.
- R3: The number of trials is 8 (8-bit unsigned), 9 (8-bit signed), 10 (10-bit unsigned) or 11 (10-bit signed). Each trial is two clocks long, so conversion takes 16, 18, 20 or 22 clocks. `int_n` goes low on the edge 6+2n clocks after the capture edge.
- R4: In signed modes the first trial is the sign trial: `sign_trial` is high for its two clocks, and the sign bit is set to `comp_in`. The magnitude trials follow, MSB first.
- R5: During a magnitude trial, `trial_code` holds the bits already decided plus the bit under trial. That bit is kept only if `comp_in` is high at the end of the trial's second clock. The first magnitude trial therefore shows 0x200.
- R6: In unsigned modes the sign bit of the result is 0. In 8-bit modes the two lowest magnitude bits are 0.
- R7: The 16-bit result word is laid out as follows:
  - Left justification: sign, then the 10 magnitude bits, then five zeros.
  - Right justification, 10-bit: the sign repeated six times, then the magnitude.
  - Right justification, 8-bit: the sign repeated eight times, then the upper 8 magnitude bits.
- R8: The first read returns word bits [15:8] and the next read returns bits [7:0]. A rising `rd_n` with `cs_n` low moves to the other byte. The pointer goes back to the high byte whenever a conversion starts or completes.
- R9: `bus_doe` is high only while both `cs_n` and `rd_n` are low.
- R10: A falling `rd_n` or `wr_n` seen while `cs_n` is low sets `int_n` high on the next edge. A falling strobe with `cs_n` high leaves `int_n` unchanged. If completion lands on the same edge as a clearing strobe, completion wins.
- R11: A write during a conversion aborts it. A new conversion starts with the new configuration, and its timing is counted from the new capture edge.
- R12: A read during a conversion returns the bytes of the previous result.
- R13: After reset:
  - `int_n` is high.
  - `sample_en`, `sign_trial` and `bus_doe` are low.
  - `chan_sel` is 0.
  - The result word reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_din | input | 8 | Configuration byte from the bus |
| bus_dout | output | 8 | Result byte to the bus |
| bus_doe | output | 1 | Output enable for the bus pads |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| chan_sel | output | 5 | Latched channel address |
| sample_en | output | 1 | High during the acquisition window |
| sign_trial | output | 1 | High during the sign trial |
| trial_code | output | 10 | Magnitude code presented to the DAC |
| comp_in | input | 1 | Comparator decision |

## Verification
A wrong state or counter value shows up as early or late timing at the ports:
- A wrong acquisition or trial count moves the falling edge of `int_n` by whole clocks, and the bench checks the exact edge of every conversion.
- A trial index that starts at the wrong bit shows up as a wrong `trial_code` on the first trial clock.
- A wrong trial index or kept-bit decision corrupts the result, which becomes visible on the next two reads.

A byte pointer that is not restored shows up as swapped bytes on the first read after the next completion.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    localparam int CHAN_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_SET,
        ST_DECIDE
    } seq_state_t;

    typedef struct packed {
        logic              left_just;
        logic              ten_bit;
        logic              signed_md;
        logic [CHAN_W-1:0] chan;
    } seq_cfg_t;

endpackage

// File: rtl/sar_strobe_edge.sv
`timescale 1ns/1ps
module sar_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] strb_q;

    for (genvar g = 0; g < N; g++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strb_q[g] <= 1'b1;
            else        strb_q[g] <= strb_n[g];
        end
        assign rise[g] = !cs_n &&  strb_n[g] && !strb_q[g];
        assign fall[g] = !cs_n && !strb_n[g] &&  strb_q[g];
    end
endmodule

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
module sar_trial_reg #(
    parameter int MAG_W = 10,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sign_first,
    input  logic             ten_bit,
    input  logic             step,
    input  logic             comp,
    output logic             sign_phase,
    output logic             last,
    output logic [MAG_W-1:0] trial_code,
    output logic             sign_nxt,
    output logic [MAG_W-1:0] mag_nxt
);
    localparam int IDX_W = $clog2(MAG_W);
    localparam int DROP  = MAG_W - LO_W;

    logic             sign_q;
    logic             sph_q;
    logic [IDX_W-1:0] idx_q;
    logic [MAG_W-1:0] mag_q;
    logic [IDX_W-1:0] stop_idx;

    assign stop_idx   = ten_bit ? '0 : IDX_W'(DROP);
    assign sign_phase = sph_q;
    assign last       = !sph_q && (idx_q == stop_idx);
    assign trial_code = sph_q ? mag_q : (mag_q | (MAG_W'(1) << idx_q));

    always_comb begin
        sign_nxt = sign_q;
        mag_nxt  = mag_q;
        if (step) begin
            if (sph_q) sign_nxt = comp;
            else       mag_nxt[idx_q] = comp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            sph_q  <= 1'b0;
            idx_q  <= IDX_W'(MAG_W-1);
            mag_q  <= '0;
        end else if (clear) begin
            sign_q <= 1'b0;
            sph_q  <= sign_first;
            idx_q  <= IDX_W'(MAG_W-1);
            mag_q  <= '0;
        end else if (step) begin
            sign_q <= sign_nxt;
            mag_q  <= mag_nxt;
            if (sph_q)        sph_q <= 1'b0;
            else if (!last)   idx_q <= idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/sar_out_fmt.sv
`timescale 1ns/1ps
module sar_out_fmt #(
    parameter int MAG_W = 10,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ptr_home,
    input  logic             ptr_adv,
    input  logic             sign_in,
    input  logic [MAG_W-1:0] mag_in,
    input  logic             signed_md,
    input  logic             ten_bit,
    input  logic             left_just,
    output logic [7:0]       byte_out
);
    localparam int WORD_W = 16;
    localparam int PAD_L  = WORD_W - 1 - MAG_W;
    localparam int EXT_HI = WORD_W - MAG_W;
    localparam int EXT_LO = WORD_W - LO_W;
    localparam int DROP   = MAG_W - LO_W;

    logic              s_eff;
    logic [MAG_W-1:0]  m_eff;
    logic [WORD_W-1:0] left_word;
    logic [WORD_W-1:0] word_nxt;
    logic [WORD_W-1:0] word_q;
    logic              lo_sel_q;

    always_comb begin
        s_eff = signed_md & sign_in;
        m_eff = mag_in;
        if (!ten_bit) m_eff[DROP-1:0] = '0;
    end

    if (PAD_L > 0) begin : g_pad
        assign left_word = {s_eff, m_eff, {PAD_L{1'b0}}};
    end else begin : g_nopad
        assign left_word = {s_eff, m_eff};
    end

    always_comb begin
        if (left_just)    word_nxt = left_word;
        else if (ten_bit) word_nxt = {{EXT_HI{s_eff}}, m_eff};
        else              word_nxt = {{EXT_LO{s_eff}}, m_eff[MAG_W-1:DROP]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            lo_sel_q <= 1'b0;
        end else begin
            if (load) word_q <= word_nxt;
            if (load || ptr_home) lo_sel_q <= 1'b0;
            else if (ptr_adv)     lo_sel_q <= !lo_sel_q;
        end
    end

    assign byte_out = lo_sel_q ? word_q[7:0] : word_q[15:8];
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int MAG_W    = 10,
    parameter int LO_W     = 8,
    parameter int ACQ_CLKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    output logic              int_n,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              sample_en,
    output logic              sign_trial,
    output logic [MAG_W-1:0]  trial_code,
    input  logic              comp_in
);
    localparam int ACQ_W = (ACQ_CLKS > 1) ? $clog2(ACQ_CLKS) : 1;

    seq_state_t       state_q, state_d;
    seq_cfg_t         cfg_q, cfg_new;
    logic [ACQ_W-1:0] acq_cnt_q;
    logic             int_n_q;
    logic [1:0]       rise, fall;
    logic             wr_start, int_clr, conv_done, trial_step;
    logic             sph, last_trial, sign_nxt;
    logic [MAG_W-1:0] mag_nxt;

    assign cfg_new = seq_cfg_t'(bus_din);

    sar_strobe_edge #(.N(2)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .strb_n ({rd_n, wr_n}),
        .rise   (rise),
        .fall   (fall)
    );

    assign wr_start = rise[0];
    assign int_clr  = fall[0] | fall[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (wr_start) begin
            state_d = ST_ACQ;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ACQ:    if (acq_cnt_q == ACQ_W'(ACQ_CLKS-1)) state_d = ST_SET;
                ST_SET:    state_d = ST_DECIDE;
                ST_DECIDE: state_d = last_trial ? ST_IDLE : ST_SET;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign trial_step = (state_q == ST_DECIDE) && !wr_start;
    assign conv_done  = trial_step && last_trial;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            acq_cnt_q <= '0;
            int_n_q   <= 1'b1;
        end else begin
            if (wr_start) cfg_q <= cfg_new;
            if (wr_start)                 acq_cnt_q <= '0;
            else if (state_q == ST_ACQ)   acq_cnt_q <= acq_cnt_q + 1'b1;
            if (conv_done)    int_n_q <= 1'b0;
            else if (int_clr) int_n_q <= 1'b1;
        end
    end

    sar_trial_reg #(.MAG_W(MAG_W), .LO_W(LO_W)) trial_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (wr_start),
        .sign_first (cfg_new.signed_md),
        .ten_bit    (cfg_q.ten_bit),
        .step       (trial_step),
        .comp       (comp_in),
        .sign_phase (sph),
        .last       (last_trial),
        .trial_code (trial_code),
        .sign_nxt   (sign_nxt),
        .mag_nxt    (mag_nxt)
    );

    sar_out_fmt #(.MAG_W(MAG_W), .LO_W(LO_W)) fmt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (conv_done),
        .ptr_home  (wr_start),
        .ptr_adv   (rise[1]),
        .sign_in   (sign_nxt),
        .mag_in    (mag_nxt),
        .signed_md (cfg_q.signed_md),
        .ten_bit   (cfg_q.ten_bit),
        .left_just (cfg_q.left_just),
        .byte_out  (bus_dout)
    );

    // outputs
    always_comb begin
        sample_en  = 1'b0;
        sign_trial = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACQ:    sample_en  = 1'b1;
            ST_SET:    sign_trial = sph;
            ST_DECIDE: sign_trial = sph;
            default:   ;
        endcase
        chan_sel = cfg_q.chan;
        int_n    = int_n_q;
        bus_doe  = !cs_n && !rd_n;
    end
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
    parameter int ACQ_CLKS = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       int_n,
    input logic       sample_en,
    input logic       sign_trial,
    input logic [4:0] chan_sel,
    input logic       start_pulse,
    input logic       done_pulse,
    input logic       clr_pulse
);
    localparam int CW = $clog2(ACQ_CLKS + 1) + 1;
    logic [CW-1:0] acq_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          acq_run <= '0;
        else if (start_pulse || !sample_en)  acq_run <= '0;
        else                                 acq_run <= acq_run + 1'b1;
    end

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pulse |=> $stable(chan_sel)); // R1
    AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (acq_run < CW'(ACQ_CLKS))); // R2
    AST_INT_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(done_pulse)); // R3
    AST_SIGN_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        sign_trial |-> !sample_en); // R4
    AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !done_pulse) |=> int_n); // R10
    AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !clr_pulse) |=> !int_n); // R10
endmodule

bind sar_seq_ctrl sar_seq_chk #(.ACQ_CLKS(ACQ_CLKS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_n       (int_n),
    .sample_en   (sample_en),
    .sign_trial  (sign_trial),
    .chan_sel    (chan_sel),
    .start_pulse (wr_start),
    .done_pulse  (conv_done),
    .clr_pulse   (int_clr)
);

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_doe, int_n, sample_en, sign_trial, comp_in;
    logic [4:0] chan_sel;
    logic [9:0] trial_code;
    logic       tgt_s = 1'b0;
    logic [9:0] tgt_m = '0;
    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    assign comp_in = sign_trial ? tgt_s : (tgt_m >= trial_code);

    sar_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .int_n(int_n), .chan_sel(chan_sel), .sample_en(sample_en),
        .sign_trial(sign_trial), .trial_code(trial_code), .comp_in(comp_in)
    );

    // cfg, sign, magnitude, expected word
    localparam logic [34:0] VEC [0:8] = '{
        {8'h05, 1'b1, 10'h3FF, 16'h00FF},
        {8'h22, 1'b1, 10'h2C7, 16'hFFB1},
        {8'h47, 1'b1, 10'h2C7, 16'h02C7},
        {8'h60, 1'b1, 10'h155, 16'hFD55},
        {8'hE1, 1'b1, 10'h155, 16'hAAA0},
        {8'h83, 1'b1, 10'h2C7, 16'h5880},
        {8'hA4, 1'b0, 10'h3FF, 16'h7F80},
        {8'hC6, 1'b0, 10'h000, 16'h0000},
        {8'h7F, 1'b0, 10'h3FF, 16'h03FF}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [7:0] c, input logic s, input logic [9:0] m);
        logic se;
        logic [9:0] me;
        se = c[5] & s;
        me = c[6] ? m : {m[9:2], 2'b00};
        if (c[7])      return {se, me, 5'b0};
        else if (c[6]) return {{6{se}}, me};
        else           return {{8{se}}, me[9:2]};
    endfunction

    function automatic int trials(input logic [7:0] c);
        return 8 + (c[6] ? 2 : 0) + (c[5] ? 1 : 0);
    endfunction

    task automatic do_write(input logic [7:0] c);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; bus_din = c;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic read_byte(output logic [7:0] b, output logic oe);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); b = bus_dout; oe = bus_doe; rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic read_word(input string tag, input logic [15:0] exp);
        logic [7:0] hi, lo;
        logic oe;
        read_byte(hi, oe);
        chk({tag, " R9 doe during read"}, 16'(oe), 16'd1);
        chk({tag, " R10 int_n after read"}, 16'(int_n), 16'd1);
        read_byte(lo, oe);
        chk({tag, " R7 R8 word"}, {hi, lo}, exp);
    endtask

    // called right after do_write, at the negedge following the capture edge
    task automatic wait_conv(input string tag, input logic [7:0] c);
        int n, sa, st;
        logic first_sign;
        n = trials(c); sa = 0; st = 0; first_sign = 1'b0;
        for (int k = 0; k <= 6 + 2*n; k++) begin
            if (k > 0) @(negedge clk);
            if (sample_en) sa++;
            if (sign_trial) st++;
            if (k == 6) first_sign = sign_trial;
            if (k == (c[5] ? 8 : 6)) chk({tag, " R5 first trial code"}, 16'(trial_code), 16'h200);
            if (k == 5 + 2*n) chk({tag, " R3 int_n before end"}, 16'(int_n), 16'd1);
            if (k == 6 + 2*n) chk({tag, " R3 int_n at end"}, 16'(int_n), 16'd0);
        end
        chk({tag, " R2 acquisition length"}, 16'(sa), 16'd6);
        chk({tag, " R4 sign trial clocks"}, 16'(st), c[5] ? 16'd2 : 16'd0);
        chk({tag, " R4 sign first"}, 16'(first_sign), 16'(c[5]));
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic oe;
        logic [7:0] c;
        logic [15:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 int_n", 16'(int_n), 16'd1);
        chk("R13 sample_en", 16'(sample_en), 16'd0);
        chk("R13 sign_trial", 16'(sign_trial), 16'd0);
        chk("R13 chan_sel", 16'(chan_sel), 16'd0);
        chk("R13 doe", 16'(bus_doe), 16'd0);
        read_word("R13 reset word", 16'h0000);

        // R9 enable gating
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk); chk("R9 doe with cs high", 16'(bus_doe), 16'd0);
        rd_n = 1'b1; cs_n = 1'b0;
        @(negedge clk); chk("R9 doe with rd high", 16'(bus_doe), 16'd0);
        cs_n = 1'b1;

        // vector table: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 9; i++) begin
            {c, tgt_s, tgt_m, e} = VEC[i];
            do_write(c);
            chk("R1 chan_sel", 16'(chan_sel), 16'(c[4:0]));
            wait_conv("vec", c);
            read_word("vec R6", e);
        end

        // R10 falling rd with cs high does not clear
        do_write(8'h40); tgt_m = 10'h123;
        wait_conv("R10 setup", 8'h40);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); chk("R10 rd fall cs high keeps int", 16'(int_n), 16'd0);
        chk("R9 doe cs high", 16'(bus_doe), 16'd0);
        rd_n = 1'b1;
        // R10 falling wr clears; rising then starts a conversion
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; bus_din = 8'h40;
        @(negedge clk); chk("R10 wr fall clears int", 16'(int_n), 16'd1);
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        wait_conv("R10 restart", 8'h40);
        // R8 single read then new start: pointer back to high byte
        read_byte(b, oe);
        chk("R8 first byte", 16'(b), 16'(model(8'h40, 1'b0, 10'h123) >> 8));
        tgt_s = 1'b1; tgt_m = 10'h2AB;
        do_write(8'h60);
        // R12 read during conversion returns previous result high byte
        read_byte(b, oe);
        chk("R12 read during conversion", 16'(b), 16'(model(8'h40, 1'b0, 10'h123) >> 8));
        for (int k = 0; k < 40 && int_n; k++) @(negedge clk);
        chk("R3 completion seen", 16'(int_n), 16'd0);
        read_word("R8 R12 after completion", model(8'h60, 1'b1, 10'h2AB));

        // R11 abort mid-conversion with a new configuration
        tgt_s = 1'b1; tgt_m = 10'h0F0;
        do_write(8'h78);
        repeat (10) @(negedge clk);
        tgt_s = 1'b0; tgt_m = 10'h3A5;
        do_write(8'h89);
        chk("R11 R1 chan after abort", 16'(chan_sel), 16'h09);
        wait_conv("R11 abort", 8'h89);
        read_word("R11 abort word", model(8'h89, 1'b0, 10'h3A5));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule